// File: doc/BRIEF.md
# Synchronous Sequential Function Chart Engine

This block runs a small sequential function chart in hardware. A chart is a set of steps, each active or inactive, joined by transitions. Each transition has a set of steps before it, a set of steps after it and one condition input. Parameter bit-masks fix the chart's structure at elaboration. On every rising clock edge the engine takes the current step activity and the condition vector. It then clears transitions pass after pass until no transition can be cleared. The resulting stable situation is loaded into the step register and into one registered action output per step, so the outputs never show an intermediate situation.

The search runs through a fixed number of passes, N_STEPS+1, built as combinational logic between clock edges. If a transition can still be cleared after the last pass, the chart is treated as invalid. The control machine then moves from ENG_RUN to ENG_FAULT and freezes the steps and the actions. ENG_FAULT keeps its state on every edge, and only the synchronous reset returns the machine to ENG_RUN. The default chart is a producer-consumer pattern with a shared semaphore step. It has steps 1 to 5 and four transitions. t1, guarded by a, goes from step 1 to steps 2 and 3. t2, guarded by not a, goes from step 2 to step 1. t3, guarded by b, goes from step 4 to step 5. t4, guarded by not b, goes from steps 3 and 5 to step 4. The produce action is step 2 and the consume action is step 5.

Top module: `sfc_engine`

## Requirements
- R1: Bit i of the step activity and of `act_o` stands for step i+1. Reset makes exactly the initial steps active. In the default chart these are steps 1 and 4 (mask 5'b01001), which `act_o` shows after the first edge following reset release when all conditions are false.
- R2: While `rst` is high, `act_o` is all zero and `unstable_o` is 0, whatever the condition inputs are.
- R3: A transition is cleared only if all of its preceding steps are active and its condition bit is 1. With the default chart, `cond_i` bits 0 to 3 drive t1 to t4.
- R4: Clearing a transition deactivates its preceding steps and activates its following steps in the same evaluation.
- R5: Every transition that is clearable in the same pass is cleared in that pass.
- R6: A step that one transition activates and another deactivates in the same pass stays active.
- R7: One edge applies as many clearing passes as needed, and `act_o` shows only the final stable situation. A transition that another one enables in the same evaluation is cleared in that same evaluation. If the conditions are held, the outputs do not change. The produce action (bit 1) and the consume action (bit 4) never rise in the same evaluation that consumes step 3.
- R8: The default chart has the structure given above, with the produce action on `act_o[1]` and the consume action on `act_o[4]`.
- R9: If a transition can still be cleared after N_STEPS+1 passes, `unstable_o` goes to 1 on that edge and stays at 1 until reset. The step activity and `act_o` keep their values until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| cond_i | input | N_TRANS | One condition per transition, sampled at each edge |
| act_o | output | N_STEPS | Registered action per step, equal to the stable step activity |
| unstable_o | output | 1 | Sticky flag that the chart failed to reach a stable situation |

## Verification
Each result is due exactly one rising edge after its condition inputs are applied. This holds for the stable step activity, for the entry into ENG_FAULT and for the reset clearing of the outputs. The bench changes inputs only on the falling edge and compares the outputs on the next falling edge, so each check sees the result of the edge in between. Directed sequences cover simultaneous clearing, activation winning over deactivation, a two-pass chain and a looping chart that cannot settle. A random run of a and b is compared every cycle against a behavioural model that iterates until nothing changes.

// File: rtl/sfc_pkg.sv
package sfc_pkg;

    // Control state of the evolution engine
    typedef enum logic [0:0] {
        ENG_RUN   = 1'b0,
        ENG_FAULT = 1'b1
    } eng_state_e;

endpackage

// File: rtl/sfc_enable.sv
// Clearability of every transition for one step situation
module sfc_enable #(
    parameter int N_STEPS = 5,
    parameter int N_TRANS = 4,
    parameter logic [N_TRANS*N_STEPS-1:0] PRE_MASK = 20'b10100_01000_00010_00001
) (
    input  logic [N_STEPS-1:0] steps_i,
    input  logic [N_TRANS-1:0] cond_i,
    output logic [N_TRANS-1:0] fire_o
);

    for (genvar t = 0; t < N_TRANS; t++) begin : g_tr
        localparam logic [N_STEPS-1:0] PRE = PRE_MASK[t*N_STEPS +: N_STEPS];
        assign fire_o[t] = cond_i[t] && ((steps_i & PRE) == PRE);
    end

endmodule

// File: rtl/sfc_pass.sv
// One clearing pass: fire all clearable transitions together
module sfc_pass #(
    parameter int N_STEPS = 5,
    parameter int N_TRANS = 4,
    parameter logic [N_TRANS*N_STEPS-1:0] PRE_MASK  = 20'b10100_01000_00010_00001,
    parameter logic [N_TRANS*N_STEPS-1:0] POST_MASK = 20'b01000_10000_00001_00110
) (
    input  logic [N_STEPS-1:0] steps_i,
    input  logic [N_TRANS-1:0] cond_i,
    output logic [N_STEPS-1:0] steps_o
);

    logic [N_TRANS-1:0] fire;
    logic [N_STEPS-1:0] drop_set;
    logic [N_STEPS-1:0] gain_set;

    sfc_enable #(
        .N_STEPS (N_STEPS),
        .N_TRANS (N_TRANS),
        .PRE_MASK(PRE_MASK)
    ) u_en (
        .steps_i(steps_i),
        .cond_i (cond_i),
        .fire_o (fire)
    );

    always_comb begin
        drop_set = '0;
        gain_set = '0;
        for (int t = 0; t < N_TRANS; t++) begin
            if (fire[t]) begin
                drop_set = drop_set | PRE_MASK[t*N_STEPS +: N_STEPS];
                gain_set = gain_set | POST_MASK[t*N_STEPS +: N_STEPS];
            end
        end
    end

    // activation has priority over deactivation
    assign steps_o = (steps_i & ~drop_set) | gain_set;

endmodule

// File: rtl/sfc_settle.sv
// Unrolled stability search over a bounded number of passes
module sfc_settle #(
    parameter int N_STEPS = 5,
    parameter int N_TRANS = 4,
    parameter int N_PASS  = 6,
    parameter logic [N_TRANS*N_STEPS-1:0] PRE_MASK  = 20'b10100_01000_00010_00001,
    parameter logic [N_TRANS*N_STEPS-1:0] POST_MASK = 20'b01000_10000_00001_00110
) (
    input  logic [N_STEPS-1:0] steps_i,
    input  logic [N_TRANS-1:0] cond_i,
    output logic [N_STEPS-1:0] settled_o,
    output logic               unstable_o
);

    logic [N_STEPS-1:0] stage [N_PASS+1];
    logic [N_TRANS-1:0] still_live;

    assign stage[0] = steps_i;

    for (genvar k = 0; k < N_PASS; k++) begin : g_pass
        sfc_pass #(
            .N_STEPS  (N_STEPS),
            .N_TRANS  (N_TRANS),
            .PRE_MASK (PRE_MASK),
            .POST_MASK(POST_MASK)
        ) u_pass (
            .steps_i(stage[k]),
            .cond_i (cond_i),
            .steps_o(stage[k+1])
        );
    end

    sfc_enable #(
        .N_STEPS (N_STEPS),
        .N_TRANS (N_TRANS),
        .PRE_MASK(PRE_MASK)
    ) u_last (
        .steps_i(stage[N_PASS]),
        .cond_i (cond_i),
        .fire_o (still_live)
    );

    assign settled_o  = stage[N_PASS];
    assign unstable_o = |still_live;

endmodule

// File: rtl/sfc_engine.sv
// Clocked chart evolution engine with stability search and fault latch
module sfc_engine
    import sfc_pkg::*;
#(
    parameter int N_STEPS = 5,
    parameter int N_TRANS = 4,
    parameter logic [N_STEPS-1:0]         INIT_MASK = 5'b01001,
    parameter logic [N_TRANS*N_STEPS-1:0] PRE_MASK  = 20'b10100_01000_00010_00001,
    parameter logic [N_TRANS*N_STEPS-1:0] POST_MASK = 20'b01000_10000_00001_00110
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_TRANS-1:0] cond_i,
    output logic [N_STEPS-1:0] act_o,
    output logic               unstable_o
);

    localparam int N_PASS = N_STEPS + 1;

    eng_state_e         state_q;
    eng_state_e         state_d;
    logic [N_STEPS-1:0] steps_q;
    logic [N_STEPS-1:0] act_q;
    logic [N_STEPS-1:0] settled;
    logic               no_settle;

    sfc_settle #(
        .N_STEPS  (N_STEPS),
        .N_TRANS  (N_TRANS),
        .N_PASS   (N_PASS),
        .PRE_MASK (PRE_MASK),
        .POST_MASK(POST_MASK)
    ) u_settle (
        .steps_i   (steps_q),
        .cond_i    (cond_i),
        .settled_o (settled),
        .unstable_o(no_settle)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ENG_RUN:   if (no_settle) state_d = ENG_FAULT;
            ENG_FAULT: state_d = ENG_FAULT;
            default:   state_d = ENG_RUN;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ENG_RUN;
        else     state_q <= state_d;
    end

    // step activity and action outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            steps_q <= INIT_MASK;
            act_q   <= '0;
        end else if (state_q == ENG_RUN && !no_settle) begin
            steps_q <= settled;
            act_q   <= settled;
        end else begin
            act_q   <= steps_q;
        end
    end

    assign act_o      = act_q;
    assign unstable_o = (state_q == ENG_FAULT);

endmodule

// File: rtl/sfc_engine_chk.sv
module sfc_engine_chk #(
    parameter int N_STEPS = 5,
    parameter int N_TRANS = 4
) (
    input logic               clk,
    input logic               rst,
    input logic [N_TRANS-1:0] cond_i,
    input logic [N_STEPS-1:0] act_o,
    input logic               unstable_o
);

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (act_o == '0 && !unstable_o)); // R2

    AST_SETTLED_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !unstable_o && cond_i == $past(cond_i)) |=> $stable(act_o)); // R7

    AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (rst)
        unstable_o |=> unstable_o); // R9

    AST_FAULT_FROZEN: assert property (@(posedge clk) disable iff (rst)
        unstable_o |=> $stable(act_o)); // R9

endmodule

bind sfc_engine sfc_engine_chk #(
    .N_STEPS(N_STEPS),
    .N_TRANS(N_TRANS)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cond_i    (cond_i),
    .act_o     (act_o),
    .unstable_o(unstable_o)
);

// File: tb/sim_sfc_engine.sv
module sim_sfc_engine;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic       rst, rst2;
    logic       a, b;
    logic [3:0] cond;
    logic [4:0] act;
    logic       unst;
    logic [1:0] c2;
    logic [1:0] act2;
    logic       unst2;
    int         checks = 0;
    int         errors = 0;
    bit         done = 0;

    assign cond = {~b, b, ~a, a};

    sfc_engine u0 (
        .clk(clk), .rst(rst), .cond_i(cond), .act_o(act), .unstable_o(unst)
    );

    // two-step loop chart: t1 step1->step2, t2 step2->step1
    sfc_engine #(
        .N_STEPS(2), .N_TRANS(2), .INIT_MASK(2'b01),
        .PRE_MASK(4'b10_01), .POST_MASK(4'b01_10)
    ) u1 (
        .clk(clk), .rst(rst2), .cond_i(c2), .act_o(act2), .unstable_o(unst2)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual %0b expected %0b", tag, got, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // behavioural model of the default chart, repeated until nothing moves
    function automatic logic [4:0] ref_next(input logic [4:0] s, input logic av, input logic bv);
        logic [4:0] cur;
        logic [4:0] off;
        logic [4:0] on;
        bit         moved;
        int         guard;
        cur   = s;
        guard = 0;
        do begin
            off   = '0;
            on    = '0;
            moved = 0;
            if (cur[0] && av)             begin off[0] = 1; on[1] = 1; on[2] = 1; moved = 1; end
            if (cur[1] && !av)            begin off[1] = 1; on[0] = 1; moved = 1; end
            if (cur[3] && bv)             begin off[3] = 1; on[4] = 1; moved = 1; end
            if (cur[2] && cur[4] && !bv)  begin off[2] = 1; off[4] = 1; on[3] = 1; moved = 1; end
            cur = (cur & ~off) | on;
            guard++;
        end while (moved && guard < 50);
        return cur;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [4:0] mstate;
        logic [4:0] exp;
        logic [4:0] prev;
        rst = 1; rst2 = 1; a = 1; b = 1; c2 = 2'b11;
        repeat (3) tick();
        chk("R2 act held zero in reset", act, 0);
        chk("R2 flag low in reset", unst, 0);
        chk("R2 loop chart act zero in reset", act2, 0);

        // R1: initial steps 1 and 4
        a = 0; b = 0; rst = 0;
        tick();
        chk("R1 initial steps", act, 5'b01001);
        // R4 / R8: t1 to steps 2 and 3
        a = 1; tick();
        chk("R4 t1 clears", act, 5'b01110);
        // R3: t4 not cleared while step 5 inactive although not b
        a = 0; tick();
        chk("R3 t4 blocked, t2 cleared", act, 5'b01101);
        b = 1; tick();
        chk("R8 t3 to step 5", act, 5'b10101);
        // R5 and R6: t1 and t4 together, step 3 stays active
        a = 1; b = 0; tick();
        chk("R5 simultaneous clearing", act[3], 1'b1);
        chk("R6 activation wins on step 3", act, 5'b01110);

        // R7: two-pass chain t1 then t4 in one evaluation
        rst = 1; tick();
        chk("R2 reset clears act", act, 0);
        rst = 0; a = 0; b = 1; tick();
        chk("R1 first edge evaluates from initial", act, 5'b10001);
        a = 1; b = 0; tick();
        chk("R7 chained clearing", act, 5'b01010);
        a = 1; b = 1; tick();
        chk("R8 t3 while producing", act, 5'b10010);
        tick();
        chk("R7 held conditions hold outputs", act, 5'b10010);

        // R9: loop chart
        rst2 = 0; c2 = 2'b01; tick();
        chk("R9 loop chart stable case", act2, 2'b10);
        chk("R9 no flag when stable", unst2, 0);
        c2 = 2'b11; tick();
        chk("R9 flag on endless clearing", unst2, 1);
        chk("R9 steps kept on fault", act2, 2'b10);
        c2 = 2'b10; tick();
        chk("R9 flag sticky", unst2, 1);
        chk("R9 steps frozen after fault", act2, 2'b10);
        rst2 = 1; tick();
        chk("R9 reset clears flag", unst2, 0);
        chk("R2 loop chart act zero", act2, 0);

        // random comparison against the model (R3 R4 R5 R6 R7)
        rst = 1; tick();
        rst = 0;
        mstate = 5'b01001;
        for (int i = 0; i < 400; i++) begin
            a = 1'($urandom % 2);
            b = 1'($urandom % 2);
            exp  = ref_next(mstate, a, b);
            prev = act;
            tick();
            chk("R7 model compare", act, exp);
            chk("R9 default chart never faults", unst, 0);
            if (mstate[2] && !exp[2])
                chk("R7 PROD and CONS not rising together", (act[1] && !prev[1]) && (act[4] && !prev[4]), 0);
            mstate = exp;
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule